// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block collects interrupt requests from forty-one sources and presents one request line to the processor. Sources 0 to 14 are external request lines and source 15 is the non-maskable source. Sources 16 to 40 belong to on-chip peripherals: debug, GPIO, DMA, timers, real-time clock, two serial ports, watchdog and refresh. Each source has a priority. The external lines and the non-maskable source have fixed priorities. The peripheral priorities come from three 16-bit configuration registers, and several sources can share one 4-bit field.

A raise pulse on a source marks it pending, unless its priority is zero. A clear pulse on the source removes it from the pending set. A combinational arbiter picks the pending source with the highest priority, and ties go to the lower source index. The request line rises when the processor's block bit is clear and its 4-bit mask level is strictly below the winner's priority. When the processor acknowledges, the block returns the winner's fixed exception code in the same cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no source is pending, `irq_req` is 0 and the three configuration registers are zero, so every peripheral source (16 to 40) has priority 0. External line n (0 to 14) has the fixed priority 15-n, and source 15 has the fixed priority 16.
- R2: A raise on a source whose current priority is 0 is dropped: the source does not become pending.
- R3: Raising a source that is already pending has no further effect, so one clear empties it.
- R4: A clear pulse removes the source from the pending set at the next clock edge. A clear wins over a raise on the same source in the same cycle.
- R5: The winner is the pending source with the highest priority. Among equal priorities the lower source index wins.
- R6: `irq_req` is 1 exactly when a winner exists, `blk_in` is 0 and `mask_lvl` is strictly less than the winner's priority. Any change to the pending set, the mask or the block bit takes effect on the output in the same cycle.
- R7: Writing `cfg_wdata` with `cfg_wr`=1 loads register `cfg_sel`, and the new value is used from the next cycle. The fields are as follows:
  - Register 0: [15:12] timer 0 (src 23), [11:8] timer 1 (24), [7:4] timer 2 and its capture source (25, 26), [3:0] the clock sources (27 to 29).
  - Register 1: [15:12] watchdog (38), [11:8] refresh (39, 40), [7:4] serial (30 to 33). Bits [3:0] are unused.
  - Register 2: [15:12] GPIO (17), [11:8] DMA (18 to 22), [7:4] FIFO serial (34 to 37), [3:0] debug (16).
- R8: The exception codes (12 bits) are:
  - source n<15: 0x200+0x20·n
  - source 15: 0x1C0
  - sources 16 to 22: 0x600+0x20·(n-16)
  - sources 23 to 33: 0x400+0x20·(n-23)
  - sources 34 to 37: 0x700+0x20·(n-34)
  - sources 38 to 40: 0x560+0x20·(n-38)
- R9: While `ack_in` is 1, `ack_code` shows the current winner's code in the same cycle, and 0 if there is no winner. It also shows 0 whenever `ack_in` is 0. An acknowledge does not clear the pending source.
- R10: A pending source whose priority is reprogrammed to 0 takes no part in arbitration from the next cycle on.
- R11: The non-maskable source (priority 16) raises `irq_req` whenever it is pending and `blk_in` is 0, even at mask level 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_raise | input | 41 | Per-source raise pulse |
| src_clear | input | 41 | Per-source clear pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0, 1, 2; 3 writes nothing) |
| cfg_wdata | input | 16 | Configuration write data |
| blk_in | input | 1 | Processor block bit |
| mask_lvl | input | 4 | Processor current mask level |
| ack_in | input | 1 | Processor acknowledge |
| irq_req | output | 1 | Interrupt request to the processor |
| ack_code | output | 12 | Exception code of the acknowledged winner |

## Verification
Some properties are checked by assertions on every cycle:
- a zero-priority raise never creates a pending bit;
- a clear always empties its source;
- the winner is eligible, and no eligible source beats it by priority or by index;
- the block bit silences the request line;
- the non-maskable source always gets through;
- an idle acknowledge returns zero.

Other behaviours only the directed scenarios can show. These are the field-to-source mapping of each configuration register, the reset priorities of the external lines, the exact code for each group of sources, the strict mask comparison at its boundary, and the fact that an acknowledge leaves the source pending.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NSRC   = 41;
  localparam int N_EXT  = 15;
  localparam int FLD_W  = 4;
  localparam int PRI_W  = FLD_W + 1;
  localparam int REG_W  = 16;
  localparam int N_REG  = 3;
  localparam int CODE_W = 12;
  localparam int IDX_W  = $clog2(NSRC);

  // Source index map; order sets the tie-break
  localparam int S_NMI  = 15;
  localparam int S_DBG  = 16;
  localparam int S_GPIO = 17;
  localparam int S_DMA0 = 18;
  localparam int S_TMR0 = 23;
  localparam int S_RTC0 = 27;
  localparam int S_SER0 = 30;
  localparam int S_FSR0 = 34;
  localparam int S_WDOG = 38;
  localparam int S_REF0 = 39;

  typedef logic [PRI_W-1:0]  pri_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [REG_W-1:0]  cfg_t;

  function automatic pri_t fld(input cfg_t r, input int lsb);
    return {1'b0, r[lsb +: FLD_W]};
  endfunction

  // Priority of one source from the three configuration registers
  function automatic pri_t src_pri(input int idx, input cfg_t ra,
                                   input cfg_t rb, input cfg_t rc);
    if (idx < N_EXT)        return pri_t'(N_EXT - idx);
    else if (idx == S_NMI)  return pri_t'(16);
    else if (idx == S_DBG)  return fld(rc, 0);
    else if (idx == S_GPIO) return fld(rc, 12);
    else if (idx < S_TMR0)  return fld(rc, 8);
    else if (idx == S_TMR0) return fld(ra, 12);
    else if (idx == S_TMR0 + 1) return fld(ra, 8);
    else if (idx < S_RTC0)  return fld(ra, 4);
    else if (idx < S_SER0)  return fld(ra, 0);
    else if (idx < S_FSR0)  return fld(rb, 4);
    else if (idx < S_WDOG)  return fld(rc, 4);
    else if (idx == S_WDOG) return fld(rb, 12);
    else                    return fld(rb, 8);
  endfunction

  // Fixed exception code, 0x20 apart inside each group
  function automatic code_t src_code(input int idx);
    int base, first;
    if (idx < N_EXT)        begin base = 'h200; first = 0;      end
    else if (idx == S_NMI)  begin base = 'h1C0; first = S_NMI;  end
    else if (idx < S_TMR0)  begin base = 'h600; first = S_DBG;  end
    else if (idx < S_FSR0)  begin base = 'h400; first = S_TMR0; end
    else if (idx < S_WDOG)  begin base = 'h700; first = S_FSR0; end
    else                    begin base = 'h560; first = S_WDOG; end
    return code_t'(base + 32 * (idx - first));
  endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [1:0]            cfg_sel,
  input  cfg_t                  cfg_wdata,
  output logic [NSRC-1:0][PRI_W-1:0] pri_o
);
  cfg_t bank_q [N_REG];

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                   bank_q[r] <= '0;
      else if (cfg_wr && int'(cfg_sel) == r)        bank_q[r] <= cfg_wdata;
    end

    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && int'(cfg_sel) == r) |=> bank_q[r] == $past(cfg_wdata));
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_pri
    assign pri_o[s] = src_pri(s, bank_q[0], bank_q[1], bank_q[2]);
  end
endmodule

// File: rtl/pic_pending.sv
module pic_pending
  import pic_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            raise_i,
  input  logic [NSRC-1:0]            clear_i,
  input  logic [NSRC-1:0][PRI_W-1:0] pri_i,
  output logic [NSRC-1:0]            pend_o,
  output logic [NSRC-1:0]            elig_o
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] live;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign live[s] = (pri_i[s] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[s] <= 1'b0;
      else        pend_q[s] <= (pend_q[s] | (raise_i[s] & live[s])) & ~clear_i[s];
    end

    a_r2_zero_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_i[s] && pri_i[s] == '0 && !pend_q[s]) |=> !pend_q[s]);

    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i[s] |=> !pend_q[s]);
  end

  assign pend_o = pend_q;
  assign elig_o = pend_q & live;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            elig_i,
  input  logic [NSRC-1:0][PRI_W-1:0] pri_i,
  output logic                       win_valid,
  output logic [IDX_W-1:0]           win_idx,
  output pri_t                       win_pri
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_pri   = '0;
    // Scan downward with >= so the lowest index keeps a tie
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (!win_valid || pri_i[i] >= win_pri)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_pri   = pri_i[i];
      end
    end
  end

  a_r5_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> elig_i[win_idx]);

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    a_r5_winner_dominates: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && elig_i[s]) |->
        (pri_i[s] < win_pri || (pri_i[s] == win_pri && s >= int'(win_idx))));
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_raise,
  input  logic [NSRC-1:0]   src_clear,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              blk_in,
  input  logic [FLD_W-1:0]  mask_lvl,
  input  logic              ack_in,
  output logic              irq_req,
  output logic [CODE_W-1:0] ack_code
);
  logic [NSRC-1:0][PRI_W-1:0] pri_w;
  logic [NSRC-1:0]            pend_w;
  logic [NSRC-1:0]            elig_w;
  logic                       win_valid;
  logic [IDX_W-1:0]           win_idx;
  pri_t                       win_pri;
  logic                       gate_open;

  pic_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pri_o(pri_w));

  pic_pending u_pend (
    .clk(clk), .rst_n(rst_n), .raise_i(src_raise), .clear_i(src_clear),
    .pri_i(pri_w), .pend_o(pend_w), .elig_o(elig_w));

  pic_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .elig_i(elig_w), .pri_i(pri_w),
    .win_valid(win_valid), .win_idx(win_idx), .win_pri(win_pri));

  assign gate_open = !blk_in && ({1'b0, mask_lvl} < win_pri);
  assign irq_req   = win_valid && gate_open;
  assign ack_code  = (ack_in && win_valid) ? src_code(int'(win_idx)) : '0;

  a_r6_block_silences: assert property (@(posedge clk) disable iff (!rst_n)
    blk_in |-> !irq_req);

  a_r11_nmi_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w[S_NMI] && !blk_in) |-> irq_req);

  a_r9_idle_ack_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_in || !(|elig_w)) |-> ack_code == '0);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [40:0] src_raise = '0;
  logic [40:0] src_clear = '0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        blk_in = 1'b0;
  logic [3:0]  mask_lvl = '0;
  logic        ack_in = 1'b0;
  logic        irq_req;
  logic [11:0] ack_code;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_raise(src_raise), .src_clear(src_clear),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .blk_in(blk_in), .mask_lvl(mask_lvl), .ack_in(ack_in),
    .irq_req(irq_req), .ack_code(ack_code));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs are read 1 ns later
  task automatic raise(input int s);
    @(negedge clk); src_raise[s] = 1'b1;
    @(negedge clk); src_raise = '0; #1;
  endtask

  task automatic clear(input int s);
    @(negedge clk); src_clear[s] = 1'b1;
    @(negedge clk); src_clear = '0; #1;
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 16'(data);
    @(negedge clk); cfg_wr = 1'b0; #1;
  endtask

  task automatic ack_chk(input string tag, input int exp);
    ack_in = 1'b1; #1;
    chk(tag, int'(ack_code), exp);
    ack_in = 1'b0; #1;
  endtask

  task automatic set_mask(input int m, input bit b);
    mask_lvl = 4'(m); blk_in = b; #1;
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", int'(irq_req), 0);
    ack_chk("R1 ack code empty", 0);
    chk("R9 code without ack", int'(ack_code), 0);
    raise(14);                          // fixed priority 1
    set_mask(0, 0);
    chk("R1 ext14 prio 1 passes mask 0", int'(irq_req), 1);
    set_mask(1, 0);
    chk("R6 ext14 prio 1 held at mask 1", int'(irq_req), 0);
    ack_chk("R8 ext14 code", 'h3C0);
    clear(14);
    set_mask(0, 0);
    chk("R4 ext14 cleared", int'(irq_req), 0);
  endtask

  task automatic t_ext_order;
    raise(3);
    chk("R6 ext3 raises irq", int'(irq_req), 1);
    ack_chk("R8 ext3 code", 'h260);
    raise(1);
    ack_chk("R5 ext1 outranks ext3", 'h220);
    set_mask(14, 0);
    chk("R6 mask equal to winner holds irq", int'(irq_req), 0);
    set_mask(13, 0);
    chk("R6 mask below winner passes", int'(irq_req), 1);
    set_mask(0, 1);
    chk("R6 block bit holds irq", int'(irq_req), 0);
    set_mask(0, 0);
    clear(1);
    ack_chk("R4 after clear ext3 wins", 'h260);
    clear(3);
    chk("R4 all cleared", int'(irq_req), 0);
  endtask

  task automatic t_zero_and_fields;
    raise(23);
    chk("R2 timer0 at prio 0 dropped", int'(irq_req), 0);
    ack_chk("R2 nothing pending", 0);
    wr(0, 'h5000);
    raise(23);
    chk("R7 timer0 field live", int'(irq_req), 1);
    ack_chk("R8 timer0 code", 'h400);
    set_mask(4, 0);
    chk("R7 timer0 prio 5 passes mask 4", int'(irq_req), 1);
    set_mask(5, 0);
    chk("R7 timer0 prio 5 held at mask 5", int'(irq_req), 0);
    set_mask(0, 0);
    clear(23);
    wr(1, 'h1230);
    raise(38);
    set_mask(1, 0);
    chk("R7 watchdog field is 1", int'(irq_req), 0);
    set_mask(0, 0);
    ack_chk("R8 watchdog code", 'h560);
    raise(40);
    set_mask(1, 0);
    ack_chk("R7 refresh field outranks watchdog", 'h5A0);
    raise(31);
    ack_chk("R7 serial field prio 3 wins", 'h500);
    clear(31); clear(40); clear(38);
    set_mask(0, 0);
    chk("R4 peripherals cleared", int'(irq_req), 0);
  endtask

  task automatic t_ties;
    wr(0, 'h0070);
    raise(26);
    ack_chk("R8 capture code", 'h460);
    raise(25);
    ack_chk("R5 tie goes to lower index", 'h440);
    clear(25); clear(26);
    wr(2, 'h0660);
    raise(34);
    ack_chk("R8 fifo serial code", 'h700);
    raise(20);
    ack_chk("R5 dma index 20 beats 34 at equal prio", 'h680);
    clear(20); clear(34);
  endtask

  task automatic t_double;
    raise(0);
    raise(0);
    ack_chk("R3 ext0 pending", 'h200);
    clear(0);
    chk("R3 one clear empties double raise", int'(irq_req), 0);
    ack_chk("R3 nothing left", 0);
    @(negedge clk); src_raise[2] = 1'b1; src_clear[2] = 1'b1;
    @(negedge clk); src_raise = '0; src_clear = '0; #1;
    chk("R4 clear beats raise", int'(irq_req), 0);
  endtask

  task automatic t_ack_and_nmi;
    raise(7);
    ack_chk("R9 first ack", 'h2E0);
    @(negedge clk); #1;
    ack_chk("R9 ack leaves source pending", 'h2E0);
    raise(15);
    set_mask(15, 0);
    chk("R11 nmi passes mask 15", int'(irq_req), 1);
    ack_chk("R11 nmi beats ext7", 'h1C0);
    set_mask(15, 1);
    chk("R6 block holds nmi", int'(irq_req), 0);
    set_mask(0, 0);
    clear(15); clear(7);
  endtask

  task automatic t_reprogram_zero;
    wr(2, 'h3000);
    raise(17);
    ack_chk("R8 gpio code", 'h620);
    wr(2, 'h0000);
    chk("R10 reprogrammed to 0 drops irq", int'(irq_req), 0);
    ack_chk("R10 no winner left", 0);
    raise(9);
    ack_chk("R10 ext9 wins", 'h320);
    clear(9); clear(17);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_ext_order();
    t_zero_and_fields();
    t_ties();
    t_double();
    t_ack_and_nmi();
    t_reprogram_zero();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule